// File: doc/BRIEF.md
# UART Per-Direction Bit Clock Selector

This block makes the timing enables for one serial channel. The receiver and the transmitter each pick their own clock source through one 8-bit select byte. The upper nibble belongs to the receiver and the lower nibble to the transmitter. The block has four kinds of source:

- a bank of fixed-rate divider taps;
- a programmable countdown timer, clocked either by the system clock or by rising edges of a shared external clock pin;
- an external clock pin for each direction, used as a 16X source;
- the shared external pin, used as a 16X source.

Each direction has two enable outputs, both one system clock wide. One is the oversampling enable (16 per bit). The other is the bit enable. In every 16X mode, a divide-by-16 phase counter makes the bit enable from the oversampling enable. One select code is reserved for external 1X operation. In that mode the direction's own pin gives the bit enable directly, one per rising edge. The oversampling enable stays quiet, and a mode flag goes high.

External pins are brought into the system clock domain by two synchronizing flops and a rising-edge detector. Writing the select byte restarts both phase counters, so a new source begins on a whole bit boundary. There is no data stream here: the select write is a single-cycle strobe with no back-pressure, and all outputs are plain enables.

Top module: `uart_dir_clksel`

## Requirements
- R1: While reset is asserted, all four tick outputs and both mode flags are 0. Reset leaves both directions on select code 0.
- R2: A one-cycle pulse on `sel_wr` stores `sel_wdata`. Bits [7:4] set the receiver code and bits [3:0] set the transmitter code. Each direction follows only its own nibble.
- R3: Select codes 0 to 11 choose fixed tap k. That tap gives an oversampling enable once every BASE_DIV * 2^k system cycles.
- R4: Code 12 chooses the timer, which gives one enable every max(`tmr_div`,1) counts. It counts system cycles when `tmr_use_ext`=0, and rising edges of `ext_shared_clk` when `tmr_use_ext`=1. A divisor of 0 acts as 1, which gives at most one enable per cycle.
- R5: Code 13 makes each rising edge of the direction's own pin (`rx_ext_clk` or `tx_ext_clk`) one oversampling enable. Code 14 does the same with `ext_shared_clk`.
- R6: Code 15 sets the direction's mode flag to 1 and keeps its oversampling enable at 0. It gives one bit enable for each rising edge of the direction's own pin.
- R7: In codes 0 to 14, the bit enable is high only in a cycle where the oversampling enable is also high, on every 16th one.
- R8: In the cycle after a select write, all tick outputs are 0. The first bit enable after the write comes with the 16th oversampling enable after it.
- R9: For codes 0 to 14, the direction's mode flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sel_wr | input | 1 | Select byte write strobe |
| sel_wdata | input | 8 | Select byte: [7:4] receiver code, [3:0] transmitter code |
| tmr_div | input | TMR_W | Timer divisor |
| tmr_use_ext | input | 1 | Timer counts shared-pin edges instead of system cycles |
| ext_shared_clk | input | 1 | Shared external clock pin (asynchronous) |
| rx_ext_clk | input | 1 | Receiver external clock pin (asynchronous) |
| tx_ext_clk | input | 1 | Transmitter external clock pin (asynchronous) |
| rx_tick16 | output | 1 | Receiver oversampling enable |
| rx_tick1 | output | 1 | Receiver bit enable |
| rx_mode_1x | output | 1 | Receiver is in external 1X mode |
| tx_tick16 | output | 1 | Transmitter oversampling enable |
| tx_tick1 | output | 1 | Transmitter bit enable |
| tx_mode_1x | output | 1 | Transmitter is in external 1X mode |

## Verification
The bench measures the spacing between enables for every source kind, in both directions at once, with different codes in each nibble. A design with swapped nibbles, or with one direction leaking into the other, would show the wrong period on one side.

It checks a divisor of 0 against a divisor of 1. Getting this wrong would make the timer stall or overflow instead of firing every cycle. It counts the oversampling enables from a select write to the first bit enable. A design that did not restart its phase counter would give a first bit short.

In 1X mode it checks that the oversampling output stays silent. A design that ran the phase counter there would report one bit per 16 pin edges.

// File: rtl/uart_clksel_pkg.sv
package uart_clksel_pkg;
  localparam int NUM_TAPS = 12;
  localparam logic [3:0] SEL_TIMER        = 4'd12;
  localparam logic [3:0] SEL_EXT16_OWN    = 4'd13;
  localparam logic [3:0] SEL_EXT16_SHARED = 4'd14;
  localparam logic [3:0] SEL_EXT1X        = 4'd15;
  localparam int N_DIR = 2;   // index 1 = receiver, 0 = transmitter
endpackage

// File: rtl/clksel_edge_sync.sv
module clksel_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise
);
  logic meta_q, sync_q, prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      prev_q <= 1'b0;
    end else begin
      meta_q <= pin;
      sync_q <= meta_q;
      prev_q <= sync_q;
    end
  end

  assign rise = sync_q & ~prev_q;
endmodule

// File: rtl/clksel_tap_bank.sv
module clksel_tap_bank #(
  parameter int BASE_DIV = 2,
  parameter int NTAPS    = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [NTAPS-1:0] taps
);
  localparam int PW = (BASE_DIV > 1) ? $clog2(BASE_DIV) : 1;

  logic             base_tick;
  logic [NTAPS-1:0] chain_q;

  generate
    if (BASE_DIV > 1) begin : g_pre
      logic [PW-1:0] pre_q;
      assign base_tick = (pre_q == PW'(BASE_DIV - 1));
      always_ff @(posedge clk) begin
        if (!rst_n)         pre_q <= '0;
        else if (base_tick) pre_q <= '0;
        else                pre_q <= pre_q + 1'b1;
      end
    end else begin : g_nopre
      assign base_tick = 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n)         chain_q <= '0;
    else if (base_tick) chain_q <= chain_q + 1'b1;
  end

  assign taps[0] = base_tick;
  generate
    for (genvar k = 1; k < NTAPS; k++) begin : g_tap
      assign taps[k] = base_tick & (&chain_q[k-1:0]);
    end
  endgenerate
endmodule

// File: rtl/clksel_timer.sv
module clksel_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             use_ext,
  input  logic             ext_rise,
  input  logic [TMR_W-1:0] div,
  output logic             tick
);
  logic [TMR_W-1:0] cnt_q;
  logic [TMR_W-1:0] eff;
  logic             step;

  assign eff  = (div == '0) ? TMR_W'(1) : div;
  assign step = use_ext ? ext_rise : 1'b1;
  assign tick = step & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) cnt_q <= '0;
    else if (step) begin
      if (cnt_q == '0) cnt_q <= eff - 1'b1;
      else             cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/clksel_dir.sv
module clksel_dir
  import uart_clksel_pkg::*;
#(
  parameter int NTAPS = NUM_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       sel,
  input  logic             restart,
  input  logic [NTAPS-1:0] taps,
  input  logic             tmr_tick,
  input  logic             own_rise,
  input  logic             shared_rise,
  output logic             tick16,
  output logic             tick1,
  output logic             mode_1x
);
  logic       src;
  logic [3:0] phase_q;

  always_comb begin
    src = 1'b0;
    case (sel)
      SEL_TIMER:        src = tmr_tick;
      SEL_EXT16_OWN:    src = own_rise;
      SEL_EXT16_SHARED: src = shared_rise;
      SEL_EXT1X:        src = own_rise;
      default: begin
        for (int k = 0; k < NTAPS; k++)
          if (sel == 4'(k)) src = taps[k];
      end
    endcase
  end

  assign mode_1x = (sel == SEL_EXT1X);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      phase_q <= '0;
      tick16  <= 1'b0;
      tick1   <= 1'b0;
    end else if (mode_1x) begin
      phase_q <= '0;
      tick16  <= 1'b0;
      tick1   <= src;
    end else begin
      tick16 <= src;
      tick1  <= src & (phase_q == 4'hF);
      if (src) phase_q <= phase_q + 1'b1;
    end
  end
endmodule

// File: rtl/uart_dir_clksel.sv
module uart_dir_clksel
  import uart_clksel_pkg::*;
#(
  parameter int BASE_DIV = 2,
  parameter int TMR_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_wr,
  input  logic [7:0]       sel_wdata,
  input  logic [TMR_W-1:0] tmr_div,
  input  logic             tmr_use_ext,
  input  logic             ext_shared_clk,
  input  logic             rx_ext_clk,
  input  logic             tx_ext_clk,
  output logic             rx_tick16,
  output logic             rx_tick1,
  output logic             rx_mode_1x,
  output logic             tx_tick16,
  output logic             tx_tick1,
  output logic             tx_mode_1x
);
  logic [7:0]          sel_q;
  logic [NUM_TAPS-1:0] taps;
  logic                shared_rise;
  logic                tmr_tick;
  logic [N_DIR-1:0]    dir_pin, dir_rise, d_t16, d_t1, d_m1;

  always_ff @(posedge clk) begin
    if (!rst_n)      sel_q <= 8'h00;
    else if (sel_wr) sel_q <= sel_wdata;
  end

  clksel_tap_bank #(.BASE_DIV(BASE_DIV), .NTAPS(NUM_TAPS)) taps_i (
    .clk(clk), .rst_n(rst_n), .taps(taps)
  );

  clksel_edge_sync shared_sync_i (
    .clk(clk), .rst_n(rst_n), .pin(ext_shared_clk), .rise(shared_rise)
  );

  clksel_timer #(.TMR_W(TMR_W)) timer_i (
    .clk(clk), .rst_n(rst_n), .use_ext(tmr_use_ext), .ext_rise(shared_rise),
    .div(tmr_div), .tick(tmr_tick)
  );

  assign dir_pin = {rx_ext_clk, tx_ext_clk};

  generate
    for (genvar g = 0; g < N_DIR; g++) begin : g_dir
      clksel_edge_sync pin_sync_i (
        .clk(clk), .rst_n(rst_n), .pin(dir_pin[g]), .rise(dir_rise[g])
      );
      clksel_dir #(.NTAPS(NUM_TAPS)) dir_i (
        .clk(clk), .rst_n(rst_n), .sel(sel_q[g*4 +: 4]), .restart(sel_wr),
        .taps(taps), .tmr_tick(tmr_tick), .own_rise(dir_rise[g]),
        .shared_rise(shared_rise), .tick16(d_t16[g]), .tick1(d_t1[g]),
        .mode_1x(d_m1[g])
      );
    end
  endgenerate

  assign rx_tick16  = d_t16[1];
  assign rx_tick1   = d_t1[1];
  assign rx_mode_1x = d_m1[1];
  assign tx_tick16  = d_t16[0];
  assign tx_tick1   = d_t1[0];
  assign tx_mode_1x = d_m1[0];
endmodule

// File: rtl/uart_dir_clksel_chk.sv
module uart_dir_clksel_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sel_wr,
  input logic [7:0] sel_wdata,
  input logic [7:0] sel_q,
  input logic       rx_tick16,
  input logic       rx_tick1,
  input logic       rx_mode_1x,
  input logic       tx_tick16,
  input logic       tx_tick1,
  input logic       tx_mode_1x
);
  logic [3:0] rx_seen, tx_seen;

  always_ff @(posedge clk) begin
    if (!rst_n || sel_wr) begin
      rx_seen <= '0;
      tx_seen <= '0;
    end else begin
      if (rx_tick16) rx_seen <= rx_seen + 1'b1;
      if (tx_tick16) tx_seen <= tx_seen + 1'b1;
    end
  end

  a_r2_store: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> sel_q == $past(sel_wdata));
  a_r6_rx_quiet16: assert property (@(posedge clk) disable iff (!rst_n)
    rx_mode_1x |-> !rx_tick16);
  a_r6_tx_quiet16: assert property (@(posedge clk) disable iff (!rst_n)
    tx_mode_1x |-> !tx_tick16);
  a_r7_rx_coincide: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tick1 && !rx_mode_1x) |-> rx_tick16);
  a_r7_tx_coincide: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick1 && !tx_mode_1x) |-> tx_tick16);
  a_r8_write_silent: assert property (@(posedge clk) disable iff (!rst_n)
    sel_wr |=> !rx_tick16 && !rx_tick1 && !tx_tick16 && !tx_tick1);
  a_r8_rx_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_tick1 && !rx_mode_1x && !sel_wr) |-> rx_seen == 4'hF);
  a_r8_tx_phase: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_tick1 && !tx_mode_1x && !sel_wr) |-> tx_seen == 4'hF);
  a_r6_rx_single: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_mode_1x && rx_tick1 && !sel_wr) |=> !rx_tick1);
endmodule

bind uart_dir_clksel uart_dir_clksel_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
  .sel_q(sel_q), .rx_tick16(rx_tick16), .rx_tick1(rx_tick1),
  .rx_mode_1x(rx_mode_1x), .tx_tick16(tx_tick16), .tx_tick1(tx_tick1),
  .tx_mode_1x(tx_mode_1x)
);

// File: tb/uart_dir_clksel_tb_top.sv
module uart_dir_clksel_tb_top;
  localparam int BASE_DIV = 2;
  localparam int TMR_W    = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_wr = 1'b0;
  logic [7:0] sel_wdata = 8'h00;
  logic [TMR_W-1:0] tmr_div = '0;
  logic tmr_use_ext = 1'b0;
  logic ext_shared_clk = 1'b0, rx_ext_clk = 1'b0, tx_ext_clk = 1'b0;
  logic rx_tick16, rx_tick1, rx_mode_1x, tx_tick16, tx_tick1, tx_mode_1x;

  int n_cmp = 0, n_bad = 0;
  int rx_half = 0, tx_half = 0, sh_half = 0;
  bit done = 0;

  always #5 clk = ~clk;

  uart_dir_clksel #(.BASE_DIV(BASE_DIV), .TMR_W(TMR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sel_wr(sel_wr), .sel_wdata(sel_wdata),
    .tmr_div(tmr_div), .tmr_use_ext(tmr_use_ext), .ext_shared_clk(ext_shared_clk),
    .rx_ext_clk(rx_ext_clk), .tx_ext_clk(tx_ext_clk),
    .rx_tick16(rx_tick16), .rx_tick1(rx_tick1), .rx_mode_1x(rx_mode_1x),
    .tx_tick16(tx_tick16), .tx_tick1(tx_tick1), .tx_mode_1x(tx_mode_1x)
  );

  initial forever begin
    if (rx_half == 0) @(negedge clk);
    else begin repeat (rx_half) @(negedge clk); rx_ext_clk = ~rx_ext_clk; end
  end
  initial forever begin
    if (tx_half == 0) @(negedge clk);
    else begin repeat (tx_half) @(negedge clk); tx_ext_clk = ~tx_ext_clk; end
  end
  initial forever begin
    if (sh_half == 0) @(negedge clk);
    else begin repeat (sh_half) @(negedge clk); ext_shared_clk = ~ext_shared_clk; end
  end

  function automatic bit sig(input int which);
    case (which)
      0: return rx_tick16;
      1: return rx_tick1;
      2: return tx_tick16;
      default: return tx_tick1;
    endcase
  endfunction

  // expected oversampling period (or bit period in 1X mode)
  function automatic int exp_period(input int code, input int div, input bit use_ext,
                                    input int own_half, input int shh);
    int eff;
    eff = (div == 0) ? 1 : div;
    if (code < 12) return BASE_DIV << code;
    if (code == 12) return use_ext ? eff * 2 * shh : eff;
    if (code == 14) return 2 * shh;
    return 2 * own_half;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_sel(input logic [7:0] v);
    @(negedge clk);
    sel_wr = 1'b1;
    sel_wdata = v;
    @(negedge clk);
    sel_wr = 1'b0;
  endtask

  task automatic wait_pulse(input int which);
    for (int t = 0; t < 40000; t++) begin
      @(negedge clk);
      if (sig(which)) return;
    end
  endtask

  task automatic measure(input int which, output int period);
    int t;
    wait_pulse(which);
    wait_pulse(which);
    t = 0;
    period = -1;
    for (int k = 0; k < 40000; k++) begin
      @(negedge clk);
      t++;
      if (sig(which)) begin period = t; break; end
    end
  endtask

  task automatic count_win(input int which, input int cycles, output int cnt);
    cnt = 0;
    for (int k = 0; k < cycles; k++) begin
      @(negedge clk);
      if (sig(which)) cnt++;
    end
  endtask

  task automatic check_dir(input string req, input bit is_tx, input int code,
                           input int exp);
    int p;
    int base;
    base = is_tx ? 2 : 0;
    if (code == 15) begin
      chk({req, " mode flag"}, is_tx ? tx_mode_1x : rx_mode_1x, 1);
      measure(base + 1, p);
      chk({req, " 1X bit period"}, p, exp);
      count_win(base, 3 * exp, p);
      chk({req, " R6 no 16X in 1X"}, p, 0);
    end else begin
      chk({req, " R9 mode flag"}, is_tx ? tx_mode_1x : rx_mode_1x, 0);
      measure(base, p);
      chk({req, " 16X period"}, p, exp);
      if (exp <= 64) begin
        measure(base + 1, p);
        chk({req, " R7 bit period"}, p, 16 * exp);
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int p, a, b, c;
    void'($urandom(32'd4711));
    // R1: reset state
    repeat (4) @(negedge clk);
    chk("R1 reset ticks", {rx_tick16, rx_tick1, tx_tick16, tx_tick1}, 0);
    chk("R1 reset modes", {rx_mode_1x, tx_mode_1x}, 0);
    @(negedge clk) rst_n = 1'b1;
    measure(0, p);
    chk("R1 default rx code 0", p, BASE_DIV);
    measure(2, p);
    chk("R1 default tx code 0", p, BASE_DIV);

    // R2/R3: independent nibbles, fixed taps
    write_sel({4'd3, 4'd1});
    check_dir("R2 R3 rx tap3", 1'b0, 3, exp_period(3, 0, 0, 0, 0));
    check_dir("R2 R3 tx tap1", 1'b1, 1, exp_period(1, 0, 0, 0, 0));

    // R7: bit enable coincides with oversampling enable
    a = 0;
    for (int k = 0; k < 600; k++) begin
      @(negedge clk);
      if (tx_tick1 && !tx_tick16) a++;
    end
    chk("R7 tx tick1 without tick16", a, 0);

    // R8: write restarts the phase
    repeat (37) @(negedge clk);
    write_sel(8'h00);
    chk("R8 silent after write", {rx_tick16, rx_tick1, tx_tick16, tx_tick1}, 0);
    b = 0;
    c = 0;
    for (int k = 0; k < 2000; k++) begin
      if (rx_tick16) b++;
      if (rx_tick1) break;
      @(negedge clk);
    end
    chk("R8 first bit at 16th sample", b, 16);

    // R4: timer, clamp and external count
    tmr_div = 0;
    write_sel({4'd12, 4'd12});
    check_dir("R4 div0 rx", 1'b0, 12, 1);
    tmr_div = 1;
    check_dir("R4 div1 tx", 1'b1, 12, 1);
    tmr_div = 5;
    check_dir("R4 div5 rx", 1'b0, 12, 5);
    sh_half = 3;
    tmr_div = 4;
    tmr_use_ext = 1'b1;
    check_dir("R4 ext count tx", 1'b1, 12, 24);
    tmr_use_ext = 1'b0;

    // R5: external 16X sources
    rx_half = 4;
    write_sel({4'd13, 4'd14});
    check_dir("R5 rx own pin", 1'b0, 13, 8);
    check_dir("R5 tx shared pin", 1'b1, 14, 6);

    // R6: external 1X
    tx_half = 5;
    write_sel({4'd0, 4'd15});
    check_dir("R6 tx 1X", 1'b1, 15, 10);
    check_dir("R2 rx unaffected", 1'b0, 0, BASE_DIV);

    // random mix
    for (int it = 0; it < 14; it++) begin
      int rc, tc, dv;
      bit ue;
      rc = $urandom_range(0, 15);
      tc = $urandom_range(0, 15);
      if (rc < 12) rc = rc % 6;
      if (tc < 12) tc = tc % 6;
      dv = $urandom_range(0, 20);
      ue = $urandom_range(0, 1);
      rx_half = $urandom_range(2, 6);
      tx_half = $urandom_range(2, 6);
      sh_half = $urandom_range(2, 5);
      tmr_div = TMR_W'(dv);
      tmr_use_ext = ue;
      write_sel({4'(rc), 4'(tc)});
      check_dir("R2 rand rx", 1'b0, rc, exp_period(rc, dv, ue, rx_half, sh_half));
      check_dir("R2 rand tx", 1'b1, tc, exp_period(tc, dv, ue, tx_half, sh_half));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule